// File: doc/BRIEF.md
# Seconds Counter With Alarm and Guarded Register Writes

This block keeps a seconds count for a chip. It derives the seconds from a slow tick input through a prescaler and compares the count with an alarm value. A level interrupt reports a seconds event or an alarm hit when the matching enable is set. Software reaches it over a simple register bus. Reads return registered data one cycle after the request. Writes are guarded in two ways. A register write is taken only after software has written a fixed unlock word. It is also taken only while a ready bit is high.

Each accepted write leaves the bus-facing side at once. It lands in its register a fixed number of cycles later, the time the slow side needs to take it. Ready stays low for that whole window. The unlock is consumed by the write it allowed, so every register update takes two bus writes. The two event flags are never cleared by accident. A zero written to a flag bit clears it, and a one leaves it as it is. Software can therefore rewrite the control register without losing an event.

Top module: `rtc_alarm_core`

## Requirements
- R1: After reset, control (offset 0x00) reads 0x0000_0080 (only the ready bit 7 set), seconds (offset 0x04) reads 0 and irq_o is low.
- R2: While no unlock is held, a write to any register other than the unlock register (offset 0x3C) changes nothing.
- R3: Writing exactly 0x0000_A55A to offset 0x3C while ready is high sets the unlock, which reads back as bit 31 of offset 0x3C. The first accepted register write clears it. A further write without a new unlock changes nothing.
- R4: An accepted write drops ready (control bit 7) in the next cycle. The new value appears in its register after WR_BUSY_CYCLES clock edges, at the same edge where ready rises. Any write made while ready is low is ignored, including the unlock word.
- R5: While the run bit (control bit 0) is set, seconds rises by one on every PRESCALE-th tick_i pulse. While run is clear, seconds holds.
- R6: The seconds-event flag (control bit 6) sets on every seconds increment, so it never sets while run is clear.
- R7: Writing 0 to control bit 6 or bit 4 clears that flag, and writing 1 leaves it unchanged. The enable bits 5, 3, 2 and 0 take the written value.
- R8: irq_o is high exactly when (bit 6 and bit 5) or (bit 4 and bit 3) of control are set.
- R9: When the alarm enable (control bit 2) is set and an increment makes seconds equal the alarm register (offset 0x08), the alarm flag (control bit 4) sets. With alarm enable clear it does not set.
- R10: The scratch register (offset 0x34) holds any 32-bit value written through an unlocked write.
- R11: A read returns, on bus_rdata_o after the next clock edge, the register value from before that edge. A seconds increment at the same edge is not visible until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Slow tick pulse, one clock wide, feeding the prescaler |
| bus_sel_i | input | 1 | Bus access request this cycle |
| bus_wr_i | input | 1 | 1 for write, 0 for read |
| bus_addr_i | input | ADDR_W | Byte offset of the register |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid the cycle after the request |
| irq_o | output | 1 | Level interrupt |

## Verification
A read returns its data one edge after the request, so the bench samples bus_rdata_o at the falling edge that follows. An accepted write shows ready low from the first edge after it. Its value lands WR_BUSY_CYCLES edges later. The bench reads in the busy window to see the old value and a cleared ready bit, then waits out the window before reading the new value. A seconds step and its flags appear at the edge of the PRESCALE-th tick pulse, and irq_o follows the flags at once. One read is issued in the same cycle as a step, and it must return the value from before the step.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
   localparam int unsigned REG_W = 32;

   localparam logic [7:0] OFF_CTRL    = 8'h00;
   localparam logic [7:0] OFF_SEC     = 8'h04;
   localparam logic [7:0] OFF_ALARM   = 8'h08;
   localparam logic [7:0] OFF_SCRATCH = 8'h34;
   localparam logic [7:0] OFF_UNLOCK  = 8'h3C;

   localparam logic [REG_W-1:0] UNLOCK_WORD = 32'h0000_A55A;
   localparam int unsigned UNLOCK_BIT = 31;

   // control bit positions (software decodes them)
   localparam int unsigned B_READY = 7;
   localparam int unsigned B_HZF   = 6;
   localparam int unsigned B_HZIE  = 5;
   localparam int unsigned B_ALF   = 4;
   localparam int unsigned B_ALIE  = 3;
   localparam int unsigned B_ALEN  = 2;
   localparam int unsigned B_RUN   = 0;

   typedef struct packed {
      logic hz_f;
      logic hz_ie;
      logic al_f;
      logic al_ie;
      logic al_en;
      logic run;
   } ctrl_t;
endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
   parameter int unsigned PRESCALE = 32768
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run_i,
   input  logic tick_i,
   output logic sec_tick_o
);
   generate
      if (PRESCALE < 1) begin : g_bad_prescale
         $error("PRESCALE must be at least 1");
      end
      if (PRESCALE == 1) begin : g_direct
         assign sec_tick_o = run_i & tick_i;
      end else begin : g_divide
         localparam int unsigned PS_W = $clog2(PRESCALE);
         localparam logic [PS_W-1:0] PS_LAST = PS_W'(PRESCALE - 1);
         logic [PS_W-1:0] ps_cnt;

         assign sec_tick_o = run_i & tick_i & (ps_cnt == PS_LAST);

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               ps_cnt <= '0;
            end else if (run_i && tick_i) begin
               ps_cnt <= (ps_cnt == PS_LAST) ? '0 : ps_cnt + 1'b1;
            end
         end
      end
   endgenerate
endmodule

// File: rtl/rtc_wr_gate.sv
module rtc_wr_gate
   import rtc_pkg::*;
#(
   parameter int unsigned ADDR_W = 8,
   parameter int unsigned BUSY   = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sel_i,
   input  logic              wr_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [REG_W-1:0]  wdata_i,
   output logic              ready_o,
   output logic              unlocked_o,
   output logic              accept_o,
   output logic              commit_o,
   output logic [ADDR_W-1:0] cm_addr_o,
   output logic [REG_W-1:0]  cm_data_o
);
   localparam int unsigned CNT_W = $clog2(BUSY + 1);
   localparam logic [ADDR_W-1:0] UNLOCK_ADDR = ADDR_W'(OFF_UNLOCK);

   generate
      if (BUSY < 1) begin : g_bad_busy
         $error("BUSY must be at least 1");
      end
   endgenerate

   logic [CNT_W-1:0] busy_cnt;
   logic             unlock_q;
   logic             wr_req;
   logic             magic_hit;

   assign ready_o    = (busy_cnt == '0);
   assign unlocked_o = unlock_q;
   assign wr_req     = sel_i & wr_i & ready_o;
   assign magic_hit  = wr_req & (addr_i == UNLOCK_ADDR) & (wdata_i == UNLOCK_WORD);
   assign accept_o   = wr_req & unlock_q & (addr_i != UNLOCK_ADDR);
   assign commit_o   = (busy_cnt == CNT_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_cnt  <= '0;
         unlock_q  <= 1'b0;
         cm_addr_o <= '0;
         cm_data_o <= '0;
      end else begin
         if (accept_o) begin
            busy_cnt  <= CNT_W'(BUSY);
            unlock_q  <= 1'b0;
            cm_addr_o <= addr_i;
            cm_data_o <= wdata_i;
         end else begin
            if (busy_cnt != '0) busy_cnt <= busy_cnt - 1'b1;
            if (magic_hit) unlock_q <= 1'b1;
         end
      end
   end
endmodule

// File: rtl/rtc_alarm_core.sv
module rtc_alarm_core
   import rtc_pkg::*;
#(
   parameter int unsigned ADDR_W         = 8,
   parameter int unsigned SEC_W          = 32,
   parameter int unsigned PRESCALE       = 32768,
   parameter int unsigned WR_BUSY_CYCLES = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_i,
   input  logic              bus_sel_i,
   input  logic              bus_wr_i,
   input  logic [ADDR_W-1:0] bus_addr_i,
   input  logic [31:0]       bus_wdata_i,
   output logic [31:0]       bus_rdata_o,
   output logic              irq_o
);
   generate
      if (SEC_W < 1 || SEC_W > REG_W) begin : g_bad_sec_w
         $error("SEC_W must be within 1..32");
      end
      if (ADDR_W < 6) begin : g_bad_addr_w
         $error("ADDR_W must cover offset 0x3C");
      end
   endgenerate

   ctrl_t              ctrl_q;
   logic [SEC_W-1:0]   sec_q;
   logic [SEC_W-1:0]   alarm_q;
   logic [REG_W-1:0]   scratch_q;
   logic [REG_W-1:0]   rdata_q;
   logic [REG_W-1:0]   rd_mux;
   logic [SEC_W-1:0]   sec_next;
   logic               sec_tick;
   logic               al_hit;

   logic               wr_ready;
   logic               wr_unlocked;
   logic               wr_accept;
   logic               wr_commit;
   logic [ADDR_W-1:0]  wr_addr;
   logic [REG_W-1:0]   wr_data;
   logic               wr_ctrl;

   rtc_prescaler #(.PRESCALE(PRESCALE)) u_presc (
      .clk        (clk),
      .rst_n      (rst_n),
      .run_i      (ctrl_q.run),
      .tick_i     (tick_i),
      .sec_tick_o (sec_tick)
   );

   rtc_wr_gate #(.ADDR_W(ADDR_W), .BUSY(WR_BUSY_CYCLES)) u_gate (
      .clk        (clk),
      .rst_n      (rst_n),
      .sel_i      (bus_sel_i),
      .wr_i       (bus_wr_i),
      .addr_i     (bus_addr_i),
      .wdata_i    (bus_wdata_i),
      .ready_o    (wr_ready),
      .unlocked_o (wr_unlocked),
      .accept_o   (wr_accept),
      .commit_o   (wr_commit),
      .cm_addr_o  (wr_addr),
      .cm_data_o  (wr_data)
   );

   assign sec_next = sec_q + 1'b1;
   assign al_hit   = sec_tick & ctrl_q.al_en & (sec_next == alarm_q);
   assign wr_ctrl  = wr_commit & (wr_addr == ADDR_W'(OFF_CTRL));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
      end else begin
         if (wr_ctrl) begin
            ctrl_q.hz_ie <= wr_data[B_HZIE];
            ctrl_q.al_ie <= wr_data[B_ALIE];
            ctrl_q.al_en <= wr_data[B_ALEN];
            ctrl_q.run   <= wr_data[B_RUN];
         end
         ctrl_q.hz_f <= (ctrl_q.hz_f & ~(wr_ctrl & ~wr_data[B_HZF])) | sec_tick;
         ctrl_q.al_f <= (ctrl_q.al_f & ~(wr_ctrl & ~wr_data[B_ALF])) | al_hit;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sec_q     <= '0;
         alarm_q   <= '0;
         scratch_q <= '0;
      end else begin
         if (wr_commit && wr_addr == ADDR_W'(OFF_SEC)) sec_q <= wr_data[SEC_W-1:0];
         else if (sec_tick)                            sec_q <= sec_next;
         if (wr_commit && wr_addr == ADDR_W'(OFF_ALARM))   alarm_q   <= wr_data[SEC_W-1:0];
         if (wr_commit && wr_addr == ADDR_W'(OFF_SCRATCH)) scratch_q <= wr_data;
      end
   end

   always_comb begin
      rd_mux = '0;
      case (bus_addr_i)
         ADDR_W'(OFF_CTRL): begin
            rd_mux[B_READY] = wr_ready;
            rd_mux[B_HZF]   = ctrl_q.hz_f;
            rd_mux[B_HZIE]  = ctrl_q.hz_ie;
            rd_mux[B_ALF]   = ctrl_q.al_f;
            rd_mux[B_ALIE]  = ctrl_q.al_ie;
            rd_mux[B_ALEN]  = ctrl_q.al_en;
            rd_mux[B_RUN]   = ctrl_q.run;
         end
         ADDR_W'(OFF_SEC):     rd_mux[SEC_W-1:0] = sec_q;
         ADDR_W'(OFF_ALARM):   rd_mux[SEC_W-1:0] = alarm_q;
         ADDR_W'(OFF_SCRATCH): rd_mux = scratch_q;
         ADDR_W'(OFF_UNLOCK):  rd_mux[UNLOCK_BIT] = wr_unlocked;
         default:              rd_mux = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                     rdata_q <= '0;
      else if (bus_sel_i && !bus_wr_i) rdata_q <= rd_mux;
   end

   assign bus_rdata_o = rdata_q;
   assign irq_o = (ctrl_q.hz_f & ctrl_q.hz_ie) | (ctrl_q.al_f & ctrl_q.al_ie);
endmodule

// File: rtl/rtc_alarm_core_chk.sv
module rtc_alarm_core_chk #(
   parameter int unsigned ADDR_W = 8,
   parameter int unsigned SEC_W  = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              accept,
   input logic              ready,
   input logic              unlocked,
   input logic              commit,
   input logic [ADDR_W-1:0] cm_addr,
   input logic              sec_tick,
   input logic              run,
   input logic [SEC_W-1:0]  sec_q,
   input logic              hz_f,
   input logic              al_f,
   input logic              irq_o
);
   assert_ready_drop_R4: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> !ready);

   assert_unlock_spent_R3: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> !unlocked);

   assert_sec_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && !commit) |=> $stable(sec_q));

   assert_sec_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (sec_tick && !commit) |=> (sec_q == $past(sec_q) + 1'b1));

   assert_hz_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
      sec_tick |=> hz_f);

   assert_flag_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(hz_f) || $fell(al_f)) |-> $past(commit && cm_addr == ADDR_W'(8'h00)));

   assert_irq_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> (hz_f || al_f));
endmodule

bind rtc_alarm_core rtc_alarm_core_chk #(.ADDR_W(ADDR_W), .SEC_W(SEC_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .accept   (wr_accept),
   .ready    (wr_ready),
   .unlocked (wr_unlocked),
   .commit   (wr_commit),
   .cm_addr  (wr_addr),
   .sec_tick (sec_tick),
   .run      (ctrl_q.run),
   .sec_q    (sec_q),
   .hz_f     (ctrl_q.hz_f),
   .al_f     (ctrl_q.al_f),
   .irq_o    (irq_o)
);

// File: tb/rtc_alarm_core_tb.sv
module rtc_alarm_core_tb;
   localparam int unsigned PS   = 4;
   localparam int unsigned BUSY = 4;
   localparam logic [7:0] A_CTRL = 8'h00, A_SEC = 8'h04, A_ALARM = 8'h08,
                          A_SCR = 8'h34, A_UNL = 8'h3C;
   localparam logic [31:0] MAGIC = 32'h0000_A55A;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick_i = 1'b0;
   logic        bus_sel_i = 1'b0;
   logic        bus_wr_i = 1'b0;
   logic [7:0]  bus_addr_i = '0;
   logic [31:0] bus_wdata_i = '0;
   logic [31:0] bus_rdata_o;
   logic        irq_o;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   rtc_alarm_core #(.ADDR_W(8), .SEC_W(32), .PRESCALE(PS), .WR_BUSY_CYCLES(BUSY)) u_dut (
      .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .bus_sel_i(bus_sel_i),
      .bus_wr_i(bus_wr_i), .bus_addr_i(bus_addr_i), .bus_wdata_i(bus_wdata_i),
      .bus_rdata_o(bus_rdata_o), .irq_o(irq_o));

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
      end
   endtask

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
      bus_sel_i = 1'b1; bus_wr_i = 1'b1; bus_addr_i = a; bus_wdata_i = d;
      @(negedge clk);
      bus_sel_i = 1'b0; bus_wr_i = 1'b0;
   endtask

   task automatic bus_rd(input logic [7:0] a, output logic [31:0] d);
      bus_sel_i = 1'b1; bus_wr_i = 1'b0; bus_addr_i = a;
      @(negedge clk);
      bus_sel_i = 1'b0;
      d = bus_rdata_o;
   endtask

   task automatic reg_write(input logic [7:0] a, input logic [31:0] d);
      bus_wr(A_UNL, MAGIC);
      bus_wr(a, d);
      cyc(BUSY);
   endtask

   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) begin
         tick_i = 1'b1;
         @(negedge clk);
         tick_i = 1'b0;
      end
   endtask

   task automatic t_reset;
      logic [31:0] d;
      bus_rd(A_CTRL, d); check("R1 ctrl after reset", d, 32'h80);
      bus_rd(A_SEC, d);  check("R1 seconds after reset", d, 0);
      check("R1 irq after reset", {31'b0, irq_o}, 0);
   endtask

   task automatic t_locked;
      logic [31:0] d;
      bus_wr(A_SEC, 32'd99);
      cyc(BUSY + 1);
      bus_rd(A_SEC, d);  check("R2 locked write ignored", d, 0);
      bus_rd(A_CTRL, d); check("R2 locked write leaves ready high", d, 32'h80);
   endtask

   task automatic t_unlock_busy;
      logic [31:0] d;
      bus_wr(A_UNL, MAGIC);
      bus_rd(A_UNL, d);  check("R3 unlock bit 31 reads set", d, 32'h8000_0000);
      bus_wr(A_SCR, 32'h1234_5678);
      bus_rd(A_CTRL, d); check("R4 ready low after accepted write", d, 32'h00);
      bus_rd(A_SCR, d);  check("R4 value not landed during busy", d, 0);
      bus_wr(A_UNL, MAGIC);
      cyc(BUSY);
      bus_rd(A_SCR, d);  check("R10 scratch holds written value", d, 32'h1234_5678);
      bus_rd(A_UNL, d);  check("R3 R4 unlock spent, busy magic ignored", d, 0);
      bus_rd(A_CTRL, d); check("R4 ready high after busy window", d, 32'h80);
      bus_wr(A_SCR, 32'hDEAD_BEEF);
      cyc(BUSY + 1);
      bus_rd(A_SCR, d);  check("R3 write after spent unlock ignored", d, 32'h1234_5678);
   endtask

   task automatic t_count;
      logic [31:0] d;
      reg_write(A_SEC, 32'd10);
      reg_write(A_CTRL, 32'h01);
      ticks(2 * PS);
      bus_rd(A_SEC, d);  check("R5 seconds after two periods", d, 32'd12);
      bus_rd(A_CTRL, d); check("R6 seconds flag set", d, 32'hC1);
      check("R8 no irq without enable", {31'b0, irq_o}, 0);
      reg_write(A_CTRL, 32'h40);
      ticks(2 * PS);
      bus_rd(A_SEC, d);  check("R5 seconds hold while stopped", d, 32'd12);
   endtask

   task automatic t_flags;
      logic [31:0] d;
      reg_write(A_CTRL, 32'h60);
      check("R8 irq on seconds flag", {31'b0, irq_o}, 1);
      bus_rd(A_CTRL, d); check("R7 writing 1 keeps flag", d, 32'hE0);
      reg_write(A_CTRL, 32'h20);
      bus_rd(A_CTRL, d); check("R7 writing 0 clears flag", d, 32'hA0);
      check("R8 irq drops with flag", {31'b0, irq_o}, 0);
      ticks(PS);
      bus_rd(A_CTRL, d); check("R6 no flag while stopped", d, 32'hA0);
   endtask

   task automatic t_alarm;
      logic [31:0] d;
      reg_write(A_ALARM, 32'd14);
      reg_write(A_CTRL, 32'h0D);
      ticks(PS);
      bus_rd(A_CTRL, d); check("R9 no alarm before match", d, 32'hCD);
      check("R8 no irq before match", {31'b0, irq_o}, 0);
      ticks(PS);
      bus_rd(A_CTRL, d); check("R9 alarm flag on match", d, 32'hDD);
      check("R8 irq on alarm", {31'b0, irq_o}, 1);
      reg_write(A_CTRL, 32'h4D);
      bus_rd(A_CTRL, d); check("R7 alarm flag cleared, seconds flag kept", d, 32'hCD);
      check("R8 irq cleared", {31'b0, irq_o}, 0);
      reg_write(A_ALARM, 32'd15);
      reg_write(A_CTRL, 32'h49);
      ticks(PS);
      bus_rd(A_SEC, d);  check("R5 seconds reached alarm value", d, 32'd15);
      bus_rd(A_CTRL, d); check("R9 no alarm flag with alarm disabled", d, 32'hC9);
   endtask

   task automatic t_snapshot;
      logic [31:0] d;
      ticks(PS - 1);
      tick_i = 1'b1; bus_sel_i = 1'b1; bus_wr_i = 1'b0; bus_addr_i = A_SEC;
      @(negedge clk);
      tick_i = 1'b0; bus_sel_i = 1'b0;
      check("R11 read at step edge returns old value", bus_rdata_o, 32'd15);
      bus_rd(A_SEC, d);  check("R11 next read shows step", d, 32'd16);
   endtask

   initial begin
      cyc(3);
      rst_n = 1'b1;
      cyc(2);
      t_reset;
      t_locked;
      t_unlock_busy;
      t_count;
      t_flags;
      t_alarm;
      t_snapshot;
      if (!done) begin
         done = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_chk++;
         n_bad++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end
endmodule